// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is the configuration front end of a programmable clock synthesizer. It sits on a two-wire serial bus as a slave. It holds the settings that the synthesizer core reads in parallel: a 10-bit oscillator tuning word, a 5-bit tuning range select, a 10-bit output divider word, a 10-bit mode word, and an address byte. The address byte carries the three device-select bits and a store-control bit. A constant, read-only range word is also visible on the bus. A bus master first writes a command byte to pick a register. It then streams data bytes into that register, or issues a repeated start and reads the register back.

SCL and SDA are oversampled by the system clock. The block drives the bus only through an open-drain pull-down. Register changes are written back to nonvolatile storage through a one-cycle store request and a busy input. Stores are requested either automatically after each write or only on an explicit store command, depending on the store-control bit. While a store is running, the slave ignores the bus.

Top module: `synth_cfg_slave`

## Requirements
- R1: After reset, the tuning word is DAC_RESET (500), the divider word is 0, the mode word is 10'h060 (bits 6 and 5 set), the range select is RANGE_WORD[15:11], the store-control bit is 0, the device select is 0, and neither SDA nor the store request is driven.
- R2: The slave acknowledges a control byte only when its upper seven bits are 1011 followed by the current device-select value. Any other control byte is not acknowledged, and the slave ignores the bus until the next start. A new device-select value is used from the next control byte onward.
- R3: Commands 08h (tuning word), 01h (divider) and 02h (mode word) take two data bytes. The first byte loads bits 9:2 and bits 7:6 of the second byte load bits 1:0. Every other bit is ignored, and so is any further byte.
- R4: Reading a 10-bit register returns bits 9:2 first, then bits 1:0 in positions 7:6 with zeros below them.
- R5: Command 0Eh writes the range select from data bits 4:0 and reads back with bits 7:5 set to 1. Command 0Dh writes the store-control bit from bit 3 and the device select from bits 2:0, and reads back with bits 7:4 at 0.
- R6: With the store-control bit at 0, a write of any register data byte makes the slave pulse the store request for one cycle a few cycles after the following stop condition.
- R7: While the store-busy input is high, the slave does not acknowledge a control byte, and it never raises the store request.
- R8: With the store-control bit at 1, register writes do not request a store. The command byte 3Fh requests one after the stop. A write to the address byte always requests one.
- R9: Command 37h reads RANGE_WORD as two bytes, high byte first. Data bytes written to it are acknowledged, change no register and request no store.
- R10: A read is a command write, a repeated start, and a control byte with the read bit set. The slave sends successive bytes while the master acknowledges. It releases SDA after a master not-acknowledge, and it changes SDA only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Serial clock line as seen on the bus |
| sdaIn | input | 1 | Serial data line as seen on the bus |
| sdaPullDown | output | 1 | 1 pulls SDA low (open-drain) |
| dacWord | output | 10 | Oscillator tuning word |
| offsetVal | output | 5 | Tuning range select |
| divWord | output | 10 | Output divider word |
| modeWord | output | 10 | Output mode bits |
| writeCtl | output | 1 | Store-control bit (1 = explicit store only) |
| devSel | output | 3 | Device-select bits of the bus address |
| storeReq | output | 1 | One-cycle request to copy registers to storage |
| storeBusy | input | 1 | Storage write in progress |

## Verification
Seeded random two-byte values are written to the tuning, divider and mode words and read back. This shows whether the high byte and the two low bits land in the right places and whether ignored bits leak into a register. Directed control bytes with a wrong device code, a wrong select value and a stale select value after an address change separate address matching from acknowledge timing. Store counting in both store-control settings, around the explicit store command and during a busy window shows whether a request is issued too often, too rarely, or while storage is busy. Reads that end with a master not-acknowledge, and writes to the read-only range command, check bus release and the discard of writes to that command.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
  localparam int WORD_W  = 10;
  localparam int LO_BITS = WORD_W - 8;
  localparam int OFF_W   = 5;
  localparam int SEL_W   = 3;
  localparam int IDX_W   = 2;

  localparam logic [7:0] CMD_DAC   = 8'h08;
  localparam logic [7:0] CMD_OFF   = 8'h0E;
  localparam logic [7:0] CMD_DIV   = 8'h01;
  localparam logic [7:0] CMD_MODE  = 8'h02;
  localparam logic [7:0] CMD_ADDR  = 8'h0D;
  localparam logic [7:0] CMD_RANGE = 8'h37;
  localparam logic [7:0] CMD_STORE = 8'h3F;
  localparam logic [3:0] DEV_CODE  = 4'b1011;

  typedef struct packed {
    logic             wrEn;
    logic [7:0]       cmd;
    logic [IDX_W-1:0] idx;
    logic [7:0]       wrData;
  } regStrobe_t;

  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} busState_t;

  function automatic logic isWritable(input logic [7:0] c);
    return (c == CMD_DAC) || (c == CMD_OFF) || (c == CMD_DIV) ||
           (c == CMD_MODE) || (c == CMD_ADDR);
  endfunction
endpackage

// File: rtl/synth_cfg_regs.sv
module synth_cfg_regs
  import synth_cfg_pkg::*;
#(
  parameter logic [WORD_W-1:0] DAC_RESET  = 10'd500,
  parameter logic [WORD_W-1:0] MODE_RESET = 10'h060,
  parameter logic [15:0]       RANGE_WORD = 16'h60A8
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  output logic [7:0]        rdData,
  output logic [WORD_W-1:0] dacQ,
  output logic [OFF_W-1:0]  offQ,
  output logic [WORD_W-1:0] divQ,
  output logic [WORD_W-1:0] modeQ,
  output logic              wcQ,
  output logic [SEL_W-1:0]  selQ
);
  localparam logic [OFF_W-1:0] OFF_RESET = RANGE_WORD[15:16-OFF_W];

  function automatic logic [7:0] wordByte(input logic [WORD_W-1:0] w,
                                          input logic [IDX_W-1:0] i);
    if (i == 0)      return w[WORD_W-1:LO_BITS];
    else if (i == 1) return {w[LO_BITS-1:0], {(8-LO_BITS){1'b0}}};
    else             return 8'h00;
  endfunction

  function automatic logic [WORD_W-1:0] wordWrite(input logic [WORD_W-1:0] w,
                                                  input logic [IDX_W-1:0] i,
                                                  input logic [7:0] d);
    logic [WORD_W-1:0] r;
    r = w;
    if (i == 0)      r[WORD_W-1:LO_BITS] = d;
    else if (i == 1) r[LO_BITS-1:0] = d[7:8-LO_BITS];
    return r;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dacQ  <= DAC_RESET;
      offQ  <= OFF_RESET;
      divQ  <= '0;
      modeQ <= MODE_RESET;
      wcQ   <= 1'b0;
      selQ  <= '0;
    end else if (strobe.wrEn) begin
      case (strobe.cmd)
        CMD_DAC:  dacQ  <= wordWrite(dacQ, strobe.idx, strobe.wrData);
        CMD_DIV:  divQ  <= wordWrite(divQ, strobe.idx, strobe.wrData);
        CMD_MODE: modeQ <= wordWrite(modeQ, strobe.idx, strobe.wrData);
        CMD_OFF:  if (strobe.idx == 0) offQ <= strobe.wrData[OFF_W-1:0];
        CMD_ADDR: if (strobe.idx == 0) begin
          wcQ  <= strobe.wrData[SEL_W];
          selQ <= strobe.wrData[SEL_W-1:0];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdData = 8'h00;
    case (strobe.cmd)
      CMD_DAC:   rdData = wordByte(dacQ, strobe.idx);
      CMD_DIV:   rdData = wordByte(divQ, strobe.idx);
      CMD_MODE:  rdData = wordByte(modeQ, strobe.idx);
      CMD_OFF:   if (strobe.idx == 0) rdData = {{(8-OFF_W){1'b1}}, offQ};
      CMD_ADDR:  if (strobe.idx == 0) rdData = {{(7-SEL_W){1'b0}}, wcQ, selQ};
      CMD_RANGE: if (strobe.idx == 0) rdData = RANGE_WORD[15:8];
                 else if (strobe.idx == 1) rdData = RANGE_WORD[7:0];
      default: ;
    endcase
  end
endmodule

// File: rtl/synth_cfg_ctrl.sv
module synth_cfg_ctrl
  import synth_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclIn,
  input  logic             sdaIn,
  input  logic [7:0]       rdData,
  input  logic             wcBit,
  input  logic [SEL_W-1:0] devSel,
  input  logic             storeBusy,
  output regStrobe_t       strobe,
  output logic             sdaPullDown,
  output logic             storeReq
);
  logic [SYNC_STAGES-1:0] sclSh, sdaSh;
  logic sclPrev, sdaPrev, sclNow, sdaNow;
  logic sclRise, sclFall, startSeen, stopSeen;
  busState_t state;
  logic [3:0] bitCnt;
  logic [1:0] byteNo;
  logic [7:0] shReg, txSh, cmdQ;
  logic [IDX_W-1:0] idxQ;
  logic readMode, pending, wrPulse, pullQ;

  assign sclNow    = sclSh[SYNC_STAGES-1];
  assign sdaNow    = sdaSh[SYNC_STAGES-1];
  assign sclRise   = sclNow & ~sclPrev;
  assign sclFall   = ~sclNow & sclPrev;
  assign startSeen = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign stopSeen  = sclNow & sclPrev & ~sdaPrev & sdaNow;

  assign strobe      = '{wrEn: wrPulse, cmd: cmdQ, idx: idxQ, wrData: shReg};
  assign sdaPullDown = pullQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSh   <= '1;
      sdaSh   <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSh   <= {sclSh[SYNC_STAGES-2:0], sclIn};
      sdaSh   <= {sdaSh[SYNC_STAGES-2:0], sdaIn};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      byteNo   <= '0;
      shReg    <= '0;
      txSh     <= '0;
      cmdQ     <= '0;
      idxQ     <= '0;
      readMode <= 1'b0;
      pending  <= 1'b0;
      wrPulse  <= 1'b0;
      pullQ    <= 1'b0;
      storeReq <= 1'b0;
    end else begin
      wrPulse  <= 1'b0;
      storeReq <= 1'b0;
      if (startSeen) begin
        state  <= ST_RX;
        bitCnt <= '0;
        byteNo <= '0;
        pullQ  <= 1'b0;
      end else if (stopSeen) begin
        state <= ST_IDLE;
        pullQ <= 1'b0;
        if (pending && !storeBusy) begin
          storeReq <= 1'b1;
          pending  <= 1'b0;
        end
      end else begin
        case (state)
          ST_RX: begin
            if (sclRise && bitCnt < 4'd8) begin
              shReg  <= {shReg[6:0], sdaNow};
              bitCnt <= bitCnt + 4'd1;
            end else if (sclFall && bitCnt == 4'd8) begin
              if (byteNo == 2'd0) begin
                if (shReg[7:1] == {DEV_CODE, devSel} && !storeBusy) begin
                  readMode <= shReg[0];
                  idxQ     <= '0;
                  pullQ    <= 1'b1;
                  state    <= ST_ACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (byteNo == 2'd1) begin
                cmdQ  <= shReg;
                idxQ  <= '0;
                pullQ <= 1'b1;
                state <= ST_ACK;
                if (shReg == CMD_STORE) pending <= 1'b1;
              end else begin
                wrPulse <= 1'b1;
                pullQ   <= 1'b1;
                state   <= ST_ACK;
                if (isWritable(cmdQ) && (!wcBit || cmdQ == CMD_ADDR)) pending <= 1'b1;
              end
            end
          end
          ST_ACK: begin
            if (sclFall) begin
              bitCnt <= '0;
              if (byteNo == 2'd2 && idxQ != '1) idxQ <= idxQ + 1'b1;
              if (byteNo != 2'd2) byteNo <= byteNo + 2'd1;
              if (readMode) begin
                txSh  <= rdData;
                pullQ <= ~rdData[7];
                state <= ST_TX;
              end else begin
                pullQ <= 1'b0;
                state <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (sclFall) begin
              if (bitCnt == 4'd7) begin
                pullQ <= 1'b0;
                state <= ST_MACK;
              end else begin
                txSh   <= {txSh[6:0], 1'b0};
                pullQ  <= ~txSh[6];
                bitCnt <= bitCnt + 4'd1;
              end
            end
          end
          ST_MACK: begin
            if (sclRise) begin
              if (sdaNow) state <= ST_IDLE;
              else if (idxQ != '1) idxQ <= idxQ + 1'b1;
            end else if (sclFall) begin
              txSh   <= rdData;
              pullQ  <= ~rdData[7];
              bitCnt <= '0;
              state  <= ST_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/synth_cfg_slave.sv
module synth_cfg_slave
  import synth_cfg_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [WORD_W-1:0] DAC_RESET   = 10'd500,
  parameter logic [WORD_W-1:0] MODE_RESET  = 10'h060,
  parameter logic [15:0]       RANGE_WORD  = 16'h60A8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic              sdaPullDown,
  output logic [WORD_W-1:0] dacWord,
  output logic [OFF_W-1:0]  offsetVal,
  output logic [WORD_W-1:0] divWord,
  output logic [WORD_W-1:0] modeWord,
  output logic              writeCtl,
  output logic [SEL_W-1:0]  devSel,
  output logic              storeReq,
  input  logic              storeBusy
);
  regStrobe_t strobe;
  logic [7:0] rdData;

  synth_cfg_ctrl #(.SYNC_STAGES(SYNC_STAGES)) i_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .rdData(rdData), .wcBit(writeCtl), .devSel(devSel), .storeBusy(storeBusy),
    .strobe(strobe), .sdaPullDown(sdaPullDown), .storeReq(storeReq)
  );

  synth_cfg_regs #(.DAC_RESET(DAC_RESET), .MODE_RESET(MODE_RESET),
                   .RANGE_WORD(RANGE_WORD)) i_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rdData(rdData),
    .dacQ(dacWord), .offQ(offsetVal), .divQ(divWord), .modeQ(modeWord),
    .wcQ(writeCtl), .selQ(devSel)
  );
endmodule

// File: rtl/synth_cfg_chk.sv
module synth_cfg_chk (
  input logic       clk,
  input logic       rstN,
  input logic       sclIn,
  input logic       sdaPullDown,
  input logic       storeReq,
  input logic       storeBusy,
  input logic [9:0] dacWord,
  input logic [9:0] divWord,
  input logic [9:0] modeWord
);
  // R6: a store request lasts exactly one cycle
  p_store_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    storeReq |=> !storeReq);

  // R7: no store request while storage is busy
  p_no_req_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    storeBusy |-> !storeReq);

  // R10: SDA drive changes only while SCL is low
  p_sda_change_low_r10: assert property (@(posedge clk) disable iff (!rstN)
    (sdaPullDown != $past(sdaPullDown)) |-> !sclIn);

  // R3: register words update only during the clock low phase
  p_dac_change_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dacWord) |-> !sclIn);

  p_div_change_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(divWord) |-> !sclIn);

  p_mode_change_low_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(modeWord) |-> !sclIn);
endmodule

bind synth_cfg_slave synth_cfg_chk i_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaPullDown(sdaPullDown),
  .storeReq(storeReq), .storeBusy(storeBusy), .dacWord(dacWord),
  .divWord(divWord), .modeWord(modeWord)
);

// File: tb/test_synth_cfg_slave.sv
module test_synth_cfg_slave;
  localparam int Q = 8;
  localparam int BUSY_CYCLES = 800;
  localparam logic [15:0] RANGE_WORD = 16'h60A8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1;
  logic sdaLine;
  logic sdaPullDown, writeCtl, storeReq, storeBusy;
  logic [9:0] dacWord, divWord, modeWord;
  logic [4:0] offsetVal;
  logic [2:0] devSel;
  int errors = 0, checks = 0, storeCnt = 0, busyCnt = 0;
  logic [2:0] expSel = 3'd0;

  always #5 clk = ~clk;
  assign sdaLine = sdaM & ~sdaPullDown;
  assign storeBusy = (busyCnt != 0);

  always @(posedge clk) begin
    if (!rstN) busyCnt <= 0;
    else if (storeReq) begin busyCnt <= BUSY_CYCLES; storeCnt <= storeCnt + 1; end
    else if (busyCnt != 0) busyCnt <= busyCnt - 1;
  end

  synth_cfg_slave i_synth_cfg_slave (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaPullDown(sdaPullDown),
    .dacWord(dacWord), .offsetVal(offsetVal), .divWord(divWord), .modeWord(modeWord),
    .writeCtl(writeCtl), .devSel(devSel), .storeReq(storeReq), .storeBusy(storeBusy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] hiOf(input logic [9:0] w); return w[9:2]; endfunction
  function automatic logic [7:0] loOf(input logic [9:0] w); return {w[1:0], 6'b0}; endfunction
  function automatic logic [9:0] wordOf(input logic [7:0] a, input logic [7:0] b);
    return {a, b[7:6]};
  endfunction

  task automatic q(); repeat (Q) @(negedge clk); endtask
  task automatic busStart(); sdaM = 1; q(); sclM = 1; q(); sdaM = 0; q(); sclM = 0; q(); endtask
  task automatic busStop(); sdaM = 0; q(); sclM = 1; q(); sdaM = 1; q(); endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; q(); sclM = 1; q(); q(); sclM = 0; q();
    end
    sdaM = 1; q(); sclM = 1; q(); ack = !sdaLine; q(); sclM = 0; q();
  endtask

  task automatic readByte(input bit mAck, output logic [7:0] b);
    sdaM = 1;
    for (int i = 7; i >= 0; i--) begin
      q(); sclM = 1; q(); b[i] = sdaLine; q(); sclM = 0;
    end
    q(); sdaM = mAck ? 1'b0 : 1'b1; q(); sclM = 1; q(); q(); sclM = 0; q(); sdaM = 1;
  endtask

  task automatic writeReg(input logic [2:0] sel, input logic [7:0] cmd, input int n,
                          input logic [7:0] d0, input logic [7:0] d1, output bit ok);
    bit a;
    busStart();
    sendByte({4'b1011, sel, 1'b0}, a); ok = a;
    if (a) begin
      sendByte(cmd, a); ok &= a;
      if (n > 0) begin sendByte(d0, a); ok &= a; end
      if (n > 1) begin sendByte(d1, a); ok &= a; end
    end
    busStop();
  endtask

  task automatic readReg(input logic [2:0] sel, input logic [7:0] cmd, input int n,
                         output logic [7:0] r0, output logic [7:0] r1, output bit ok);
    bit a;
    r0 = 8'hxx; r1 = 8'hxx;
    busStart();
    sendByte({4'b1011, sel, 1'b0}, a); ok = a;
    sendByte(cmd, a); ok &= a;
    busStart();
    sendByte({4'b1011, sel, 1'b1}, a); ok &= a;
    readByte(n > 1, r0);
    if (n > 1) readByte(1'b0, r1);
    busStop();
  endtask

  task automatic settle(); repeat (BUSY_CYCLES + 100) @(negedge clk); endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    bit ok, a;
    logic [7:0] r0, r1, d0, d1, cmd;
    logic [9:0] expW;
    int sc;
    void'($urandom(32'h5eed1234));
    repeat (5) @(negedge clk);
    rstN = 1;
    repeat (3) @(negedge clk);

    // R1 reset defaults
    chk(dacWord == 10'd500, "R1 dac", dacWord, 500);
    chk(divWord == 10'd0, "R1 div", divWord, 0);
    chk(modeWord == 10'h060, "R1 mode", modeWord, 10'h060);
    chk(offsetVal == RANGE_WORD[15:11], "R1 offset", offsetVal, RANGE_WORD[15:11]);
    chk(writeCtl == 0 && devSel == 0, "R1 addr", {writeCtl, devSel}, 0);
    chk(sdaPullDown == 0 && storeReq == 0, "R1 idle outputs", {sdaPullDown, storeReq}, 0);

    // R4 read default tuning word
    readReg(3'd0, 8'h08, 2, r0, r1, ok);
    chk(ok && r0 == hiOf(10'd500) && r1 == loOf(10'd500), "R4 default read",
        {r0, r1}, {hiOf(10'd500), loOf(10'd500)});

    // R2 mismatched select and mismatched code
    busStart(); sendByte({4'b1011, 3'd3, 1'b0}, a); busStop();
    chk(!a, "R2 wrong select nack", a, 0);
    busStart(); sendByte({4'b1010, 3'd0, 1'b0}, a); busStop();
    chk(!a, "R2 wrong code nack", a, 0);

    // R3 R6 auto store on tuning write, then R7 nack while busy
    d0 = 8'($urandom); d1 = 8'($urandom);
    sc = storeCnt;
    writeReg(3'd0, 8'h08, 2, d0, d1, ok);
    repeat (10) @(negedge clk);
    chk(ok && dacWord == wordOf(d0, d1), "R3 dac write", dacWord, wordOf(d0, d1));
    chk(storeCnt == sc + 1, "R6 auto store", storeCnt - sc, 1);
    busStart(); sendByte({4'b1011, 3'd0, 1'b0}, a); busStop();
    chk(!a && storeBusy, "R7 nack while busy", a, 0);
    settle();

    // R5 range select write and read back
    d0 = 8'($urandom);
    writeReg(3'd0, 8'h0E, 1, d0, 8'h00, ok);
    chk(ok && offsetVal == d0[4:0], "R5 offset write", offsetVal, d0[4:0]);
    settle();
    readReg(3'd0, 8'h0E, 1, r0, r1, ok);
    chk(ok && r0 == {3'b111, d0[4:0]}, "R5 offset read", r0, {3'b111, d0[4:0]});

    // R9 range read and discarded write
    readReg(3'd0, 8'h37, 2, r0, r1, ok);
    chk(ok && {r0, r1} == RANGE_WORD, "R9 range read", {r0, r1}, RANGE_WORD);
    sc = storeCnt; expW = dacWord;
    writeReg(3'd0, 8'h37, 2, 8'h12, 8'h34, ok);
    repeat (10) @(negedge clk);
    chk(ok && storeCnt == sc && dacWord == expW, "R9 range write discarded",
        storeCnt - sc, 0);
    readReg(3'd0, 8'h37, 2, r0, r1, ok);
    chk({r0, r1} == RANGE_WORD, "R9 range unchanged", {r0, r1}, RANGE_WORD);

    // R8 address write with store-control set stores
    sc = storeCnt;
    writeReg(3'd0, 8'h0D, 1, 8'h08, 8'h00, ok);
    repeat (10) @(negedge clk);
    chk(ok && writeCtl == 1 && storeCnt == sc + 1, "R8 addr write store",
        storeCnt - sc, 1);
    settle();

    // R3 R4 R8 R10 random register traffic with explicit store mode
    for (int it = 0; it < 12; it++) begin
      case ($urandom % 3)
        0: cmd = 8'h08;
        1: cmd = 8'h01;
        default: cmd = 8'h02;
      endcase
      d0 = 8'($urandom); d1 = 8'($urandom);
      sc = storeCnt;
      writeReg(3'd0, cmd, 2, d0, d1, ok);
      repeat (10) @(negedge clk);
      expW = wordOf(d0, d1);
      case (cmd)
        8'h08: chk(ok && dacWord == expW, "R3 dac random", dacWord, expW);
        8'h01: chk(ok && divWord == expW, "R3 div random", divWord, expW);
        default: chk(ok && modeWord == expW, "R3 mode random", modeWord, expW);
      endcase
      chk(storeCnt == sc, "R8 no auto store", storeCnt - sc, 0);
      readReg(3'd0, cmd, 2, r0, r1, ok);
      chk(ok && r0 == hiOf(expW) && r1 == loOf(expW), "R4 R10 read back",
          {r0, r1}, {hiOf(expW), loOf(expW)});
    end

    // R3 extra byte ignored
    expW = divWord;
    busStart();
    sendByte(8'hB0, a); sendByte(8'h01, a);
    sendByte(8'hA5, a); sendByte(8'hC0, a); sendByte(8'hFF, a);
    busStop();
    chk(divWord == wordOf(8'hA5, 8'hC0), "R3 third byte ignored", divWord,
        wordOf(8'hA5, 8'hC0));

    // R8 explicit store command
    sc = storeCnt;
    writeReg(3'd0, 8'h3F, 0, 8'h00, 8'h00, ok);
    repeat (10) @(negedge clk);
    chk(ok && storeCnt == sc + 1, "R8 explicit store", storeCnt - sc, 1);
    settle();

    // R2 R5 change select to 5
    expSel = 3'd5;
    writeReg(3'd0, 8'h0D, 1, 8'hFD, 8'h00, ok);
    repeat (10) @(negedge clk);
    chk(ok && devSel == expSel && writeCtl == 1, "R5 addr write", devSel, expSel);
    settle();
    busStart(); sendByte({4'b1011, 3'd0, 1'b0}, a); busStop();
    chk(!a, "R2 old select nack", a, 0);
    readReg(expSel, 8'h0D, 1, r0, r1, ok);
    chk(ok && r0 == 8'h0D, "R5 addr read upper zero", r0, 8'h0D);

    // R10 release after master nack
    readReg(expSel, 8'h02, 1, r0, r1, ok);
    chk(sdaPullDown == 0, "R10 release after nack", sdaPullDown, 0);
    chk(ok && r0 == hiOf(modeWord), "R10 single byte read", r0, hiOf(modeWord));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule